// File: doc/BRIEF.md
# Lockstep Wide-Word Issue Unit

This block takes one wide instruction word at a time. The word holds four fixed slots, and each slot drives exactly one functional unit with no steering between them. Slots 0 and 1 drive single-cycle integer ALUs. Slot 2 drives a pipelined multiplier. Slot 3 drives a load/store unit that owns a small local data memory. The unit assumes the slots of a word are independent, so it does no hazard checking, renaming or reordering between them.

All slots start on the same clock edge and read their register operands together at that moment. A busy counter is loaded with the latency of the slowest active slot. When the counter runs out, every result of the word is written to the shared register file in one commit cycle. Only then does the unit accept the next word.

The controller is a three-state machine:
- `ST_IDLE` waits for a word and is the only state that asserts ready.
- `ST_WAIT` counts down the remaining execution cycles.
- `ST_COMMIT` is the single write-back cycle.

Its transitions are:
- issue-short: `ST_IDLE` to `ST_COMMIT` when the accepted word has latency 1.
- issue-long: `ST_IDLE` to `ST_WAIT` when the latency is greater than 1.
- count-out: `ST_WAIT` to `ST_COMMIT` when the counter reaches 1.
- retire: `ST_COMMIT` to `ST_IDLE`.

Top module: `vliw_lockstep_issue`

## Requirements
- R1: After reset `bnd_ready` is 1 and `wb_en` is 0. `bnd_ready` is 1 only while the unit is idle, and it is 0 in every cycle between acceptance and commit.
- R2: A word accepted at clock edge e commits (asserts `wb_en`) in the cycle after edge e+L-1. L is the largest latency among active slots: ALU 1, multiply 3 (`MUL_LAT`), load/store 2 (`LS_LAT`). A word with no active slot has L = 1. `bnd_ready` returns in the cycle after the commit.
- R3: ALU slot opcodes (3 bits) are: 0 NOP, 1 ADD a+b, 2 SUB a-b, 3 AND, 4 OR, 5 XOR, 6 ADDI a+zero-extended imm, 7 LI zero-extended imm. Results are taken modulo 2^16.
- R4: Multiply slot opcode 1 writes the low 16 bits of a*b.
- R5: Load/store slot opcode 1 loads mem[(a+imm) mod 16] into rd, and opcode 2 stores b to that address. The store lands at commit. The address wraps modulo the memory depth.
- R6: Every slot reads its operands at issue, so a slot sees register values from before its own word, even when another slot of the same word writes that register.
- R7: When several slots of one word write the same register, the highest-numbered slot wins.
- R8: A NOP slot has no architectural effect: its `wb_en` bit stays 0. Multiply opcodes other than 1 and load/store opcodes 0 and 3..7 are NOPs.
- R9: A word presented while the unit is busy is neither accepted nor executed.
- R10: Every write of a word appears in one single commit cycle. `wb_en` is 0 in all other cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bnd_valid | input | 1 | A word is presented |
| bnd_ready | output | 1 | Unit idle, word accepted this cycle if valid |
| bnd_op | input | 12 | Per-slot 3-bit opcode, slot s at bits [3s+2:3s] |
| bnd_rd | input | 12 | Per-slot destination register |
| bnd_rs1 | input | 12 | Per-slot first source register |
| bnd_rs2 | input | 12 | Per-slot second source register |
| bnd_imm | input | 32 | Per-slot 8-bit immediate, slot s at bits [8s+7:8s] |
| wb_en | output | 4 | Per-slot write-back strobe, high only in the commit cycle |
| wb_rd | output | 12 | Per-slot write-back register index |
| wb_data | output | 64 | Per-slot 16-bit write-back value |

## Verification
The bench runs every opcode of every slot over register-dependent operands and drives all sixteen patterns of active slots to pin down the commit cycle. A unit that waited on the wrong slot, or let each unit commit on its own, would show `wb_en` early, split or late. Directed words place a write and a read of the same register in one word, and have three slots target one destination. A design that forwarded inside a word would return the new value, and wrong write priority would leave the wrong slot's result. Load/store addresses are swept past the memory depth to catch a missing wrap. A second word is held on the input through a long multiply to catch acceptance while busy. The reserved opcodes are driven to show that they write nothing.

// File: rtl/vliw_pkg.sv
package vliw_pkg;

    localparam int SLOT_CNT  = 4;
    localparam int OP_W      = 3;
    localparam int ALU_SLOTS = 2;
    localparam int MUL_SLOT  = 2;
    localparam int LS_SLOT   = 3;

    typedef enum logic [OP_W-1:0] {
        ALU_NOP  = 3'd0,
        ALU_ADD  = 3'd1,
        ALU_SUB  = 3'd2,
        ALU_AND  = 3'd3,
        ALU_OR   = 3'd4,
        ALU_XOR  = 3'd5,
        ALU_ADDI = 3'd6,
        ALU_LI   = 3'd7
    } alu_op_e;

    localparam logic [OP_W-1:0] MUL_OP_MUL  = 3'd1;
    localparam logic [OP_W-1:0] LS_OP_LOAD  = 3'd1;
    localparam logic [OP_W-1:0] LS_OP_STORE = 3'd2;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_WAIT   = 2'd1,
        ST_COMMIT = 2'd2
    } issue_state_e;

    // Does an opcode in a given slot produce a register write?
    function automatic logic slot_writes(input int unsigned slot, input logic [OP_W-1:0] op);
        if (slot < ALU_SLOTS)
            return op != ALU_NOP;
        else if (slot == MUL_SLOT)
            return op == MUL_OP_MUL;
        else
            return op == LS_OP_LOAD;
    endfunction

endpackage

// File: rtl/vliw_regfile.sv
module vliw_regfile #(
    parameter int DATA_W   = 16,
    parameter int REG_AW   = 3,
    parameter int RD_PORTS = 8,
    parameter int WR_PORTS = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [RD_PORTS*REG_AW-1:0]   rd_addr,
    output logic [RD_PORTS*DATA_W-1:0]   rd_data,
    input  logic [WR_PORTS-1:0]          wr_en,
    input  logic [WR_PORTS*REG_AW-1:0]   wr_addr,
    input  logic [WR_PORTS*DATA_W-1:0]   wr_data
);
    localparam int REG_CNT = 1 << REG_AW;

    logic [DATA_W-1:0] regs     [REG_CNT];
    logic [DATA_W-1:0] regs_nxt [REG_CNT];

    genvar p;
    generate
        for (p = 0; p < RD_PORTS; p++) begin : g_rd
            assign rd_data[p*DATA_W +: DATA_W] = regs[rd_addr[p*REG_AW +: REG_AW]];
        end
    endgenerate

    // Ports applied in ascending order: a later (higher) port overrides.
    always_comb begin
        regs_nxt = regs;
        for (int w = 0; w < WR_PORTS; w++) begin
            if (wr_en[w])
                regs_nxt[wr_addr[w*REG_AW +: REG_AW]] = wr_data[w*DATA_W +: DATA_W];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < REG_CNT; i++)
                regs[i] <= '0;
        end else begin
            regs <= regs_nxt;
        end
    end

endmodule

// File: rtl/vliw_alu.sv
module vliw_alu #(
    parameter int DATA_W = 16,
    parameter int IMM_W  = 8,
    parameter int OP_W   = vliw_pkg::OP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue,
    input  logic [OP_W-1:0]   op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic [IMM_W-1:0]  imm,
    output logic [DATA_W-1:0] result
);
    import vliw_pkg::*;

    logic [DATA_W-1:0] calc;
    logic [DATA_W-1:0] imm_ext;

    assign imm_ext = DATA_W'(imm);

    always_comb begin
        unique case (alu_op_e'(op))
            ALU_ADD:  calc = a + b;
            ALU_SUB:  calc = a - b;
            ALU_AND:  calc = a & b;
            ALU_OR:   calc = a | b;
            ALU_XOR:  calc = a ^ b;
            ALU_ADDI: calc = a + imm_ext;
            ALU_LI:   calc = imm_ext;
            default:  calc = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            result <= '0;
        else if (issue)
            result <= calc;
    end

    // Result must hold from issue until commit, whatever the ports do.
    assert_result_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !issue |=> $stable(result));

endmodule

// File: rtl/vliw_mul_unit.sv
module vliw_mul_unit #(
    parameter int DATA_W = 16,
    parameter int LAT    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] result
);
    logic [DATA_W-1:0] stage [LAT];
    logic [DATA_W-1:0] product;

    assign product = a * b;

    always_ff @(posedge clk) begin
        if (!rst_n)
            stage[0] <= '0;
        else if (issue)
            stage[0] <= product;
    end

    genvar i;
    generate
        for (i = 1; i < LAT; i++) begin : g_pipe
            always_ff @(posedge clk) begin
                if (!rst_n)
                    stage[i] <= '0;
                else
                    stage[i] <= stage[i-1];
            end
        end
    endgenerate

    assign result = stage[LAT-1];

    // Operands are sampled only at issue (R6).
    assert_operands_latched_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !issue |=> $stable(stage[0]));

endmodule

// File: rtl/vliw_ls_unit.sv
module vliw_ls_unit #(
    parameter int DATA_W = 16,
    parameter int IMM_W  = 8,
    parameter int MEM_AW = 4,
    parameter int LAT    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue,
    input  logic [DATA_W-1:0] base,
    input  logic [DATA_W-1:0] store_val,
    input  logic [IMM_W-1:0]  imm,
    input  logic              store_commit,
    output logic [DATA_W-1:0] result
);
    localparam int MEM_DEPTH = 1 << MEM_AW;

    logic [DATA_W-1:0] mem [MEM_DEPTH];
    logic [DATA_W-1:0] stage [LAT];
    logic [MEM_AW-1:0] addr;
    logic [MEM_AW-1:0] st_addr_q;
    logic [DATA_W-1:0] st_data_q;

    // Modulo-depth address: the sum is truncated to the memory index width.
    assign addr = MEM_AW'(base + DATA_W'(imm));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage[0]  <= '0;
            st_addr_q <= '0;
            st_data_q <= '0;
        end else if (issue) begin
            stage[0]  <= mem[addr];
            st_addr_q <= addr;
            st_data_q <= store_val;
        end
    end

    genvar i;
    generate
        for (i = 1; i < LAT; i++) begin : g_pipe
            always_ff @(posedge clk) begin
                if (!rst_n)
                    stage[i] <= '0;
                else
                    stage[i] <= stage[i-1];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < MEM_DEPTH; k++)
                mem[k] <= '0;
        end else if (store_commit) begin
            mem[st_addr_q] <= st_data_q;
        end
    end

    assign result = stage[LAT-1];

    // A store lands only at commit, never on the issue edge (R5).
    assert_store_after_issue_R5: assert property (@(posedge clk) disable iff (!rst_n)
        issue |-> !store_commit);

endmodule

// File: rtl/vliw_issue_ctrl.sv
module vliw_issue_ctrl #(
    parameter int SLOTS   = vliw_pkg::SLOT_CNT,
    parameter int OP_W    = vliw_pkg::OP_W,
    parameter int REG_AW  = 3,
    parameter int MUL_LAT = 3,
    parameter int LS_LAT  = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bnd_valid,
    input  logic [SLOTS*OP_W-1:0]    op_in,
    input  logic [SLOTS*REG_AW-1:0]  rd_in,
    output logic                     bnd_ready,
    output logic                     issue,
    output logic                     commit,
    output logic [SLOTS*OP_W-1:0]    op_q,
    output logic [SLOTS*REG_AW-1:0]  rd_q
);
    import vliw_pkg::*;

    localparam int MAX_LAT = (MUL_LAT > LS_LAT) ? MUL_LAT : LS_LAT;
    localparam int CNT_W   = $clog2(MAX_LAT + 1);

    issue_state_e       state, state_nxt;
    logic [CNT_W-1:0]   cnt;
    logic [CNT_W-1:0]   lat;
    logic [OP_W-1:0]    mul_op_in, ls_op_in;

    assign mul_op_in = op_in[MUL_SLOT*OP_W +: OP_W];
    assign ls_op_in  = op_in[LS_SLOT*OP_W +: OP_W];

    // Latency of the slowest active slot; ALU slots and all-NOP give 1.
    always_comb begin
        lat = CNT_W'(1);
        if (mul_op_in == MUL_OP_MUL && CNT_W'(MUL_LAT) > lat)
            lat = CNT_W'(MUL_LAT);
        if ((ls_op_in == LS_OP_LOAD || ls_op_in == LS_OP_STORE) && CNT_W'(LS_LAT) > lat)
            lat = CNT_W'(LS_LAT);
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nxt;
    end

    // Transitions
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:   if (bnd_valid)
                           state_nxt = (lat == CNT_W'(1)) ? ST_COMMIT : ST_WAIT;
            ST_WAIT:   if (cnt == CNT_W'(1))
                           state_nxt = ST_COMMIT;
            ST_COMMIT: state_nxt = ST_IDLE;
            default:   state_nxt = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        bnd_ready = 1'b0;
        commit    = 1'b0;
        unique case (state)
            ST_IDLE:   bnd_ready = 1'b1;
            ST_WAIT:   ;
            ST_COMMIT: commit = 1'b1;
            default:   ;
        endcase
    end

    assign issue = bnd_ready && bnd_valid;

    // Busy counter and captured word control
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            op_q <= '0;
            rd_q <= '0;
        end else if (issue) begin
            cnt  <= lat - CNT_W'(1);
            op_q <= op_in;
            rd_q <= rd_in;
        end else if (state == ST_WAIT) begin
            cnt  <= cnt - CNT_W'(1);
        end
    end

    assert_commit_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !commit);

    assert_wait_counts_down_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT) |=> (cnt == $past(cnt) - CNT_W'(1)));

    assert_wait_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT) |-> (cnt != '0));

endmodule

// File: rtl/vliw_lockstep_issue.sv
module vliw_lockstep_issue #(
    parameter int DATA_W  = 16,
    parameter int REG_AW  = 3,
    parameter int IMM_W   = 8,
    parameter int MEM_AW  = 4,
    parameter int MUL_LAT = 3,
    parameter int LS_LAT  = 2
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic                                    bnd_valid,
    output logic                                    bnd_ready,
    input  logic [vliw_pkg::SLOT_CNT*vliw_pkg::OP_W-1:0] bnd_op,
    input  logic [vliw_pkg::SLOT_CNT*REG_AW-1:0]    bnd_rd,
    input  logic [vliw_pkg::SLOT_CNT*REG_AW-1:0]    bnd_rs1,
    input  logic [vliw_pkg::SLOT_CNT*REG_AW-1:0]    bnd_rs2,
    input  logic [vliw_pkg::SLOT_CNT*IMM_W-1:0]     bnd_imm,
    output logic [vliw_pkg::SLOT_CNT-1:0]           wb_en,
    output logic [vliw_pkg::SLOT_CNT*REG_AW-1:0]    wb_rd,
    output logic [vliw_pkg::SLOT_CNT*DATA_W-1:0]    wb_data
);
    import vliw_pkg::*;

    localparam int SL       = SLOT_CNT;
    localparam int RD_PORTS = 2 * SL;

    logic                      issue, commit;
    logic [SL*OP_W-1:0]        op_q;
    logic [SL*REG_AW-1:0]      rd_q;
    logic [RD_PORTS*DATA_W-1:0] rf_rd_data;
    logic [DATA_W-1:0]         opnd_a   [SL];
    logic [DATA_W-1:0]         opnd_b   [SL];
    logic [DATA_W-1:0]         unit_res [SL];
    logic                      store_commit;
    logic [IMM_W-1:0]          unused_mul_imm;

    assign unused_mul_imm = bnd_imm[MUL_SLOT*IMM_W +: IMM_W];

    vliw_issue_ctrl #(
        .SLOTS   (SL),
        .OP_W    (OP_W),
        .REG_AW  (REG_AW),
        .MUL_LAT (MUL_LAT),
        .LS_LAT  (LS_LAT)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .bnd_valid (bnd_valid),
        .op_in     (bnd_op),
        .rd_in     (bnd_rd),
        .bnd_ready (bnd_ready),
        .issue     (issue),
        .commit    (commit),
        .op_q      (op_q),
        .rd_q      (rd_q)
    );

    // Read ports 0..SL-1 serve rs1, SL..2SL-1 serve rs2, all sampled at issue.
    vliw_regfile #(
        .DATA_W   (DATA_W),
        .REG_AW   (REG_AW),
        .RD_PORTS (RD_PORTS),
        .WR_PORTS (SL)
    ) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_addr ({bnd_rs2, bnd_rs1}),
        .rd_data (rf_rd_data),
        .wr_en   (wb_en),
        .wr_addr (wb_rd),
        .wr_data (wb_data)
    );

    genvar s;
    generate
        for (s = 0; s < SL; s++) begin : g_opnd
            assign opnd_a[s] = rf_rd_data[s*DATA_W +: DATA_W];
            assign opnd_b[s] = rf_rd_data[(SL+s)*DATA_W +: DATA_W];
        end

        for (s = 0; s < ALU_SLOTS; s++) begin : g_alu
            vliw_alu #(
                .DATA_W (DATA_W),
                .IMM_W  (IMM_W),
                .OP_W   (OP_W)
            ) u_alu (
                .clk    (clk),
                .rst_n  (rst_n),
                .issue  (issue),
                .op     (bnd_op[s*OP_W +: OP_W]),
                .a      (opnd_a[s]),
                .b      (opnd_b[s]),
                .imm    (bnd_imm[s*IMM_W +: IMM_W]),
                .result (unit_res[s])
            );
        end
    endgenerate

    vliw_mul_unit #(
        .DATA_W (DATA_W),
        .LAT    (MUL_LAT)
    ) u_mul (
        .clk    (clk),
        .rst_n  (rst_n),
        .issue  (issue),
        .a      (opnd_a[MUL_SLOT]),
        .b      (opnd_b[MUL_SLOT]),
        .result (unit_res[MUL_SLOT])
    );

    assign store_commit = commit && (op_q[LS_SLOT*OP_W +: OP_W] == LS_OP_STORE);

    vliw_ls_unit #(
        .DATA_W (DATA_W),
        .IMM_W  (IMM_W),
        .MEM_AW (MEM_AW),
        .LAT    (LS_LAT)
    ) u_ls (
        .clk          (clk),
        .rst_n        (rst_n),
        .issue        (issue),
        .base         (opnd_a[LS_SLOT]),
        .store_val    (opnd_b[LS_SLOT]),
        .imm          (bnd_imm[LS_SLOT*IMM_W +: IMM_W]),
        .store_commit (store_commit),
        .result       (unit_res[LS_SLOT])
    );

    generate
        for (s = 0; s < SL; s++) begin : g_wb
            assign wb_en[s]                   = commit && slot_writes(s, op_q[s*OP_W +: OP_W]);
            assign wb_rd[s*REG_AW +: REG_AW]  = rd_q[s*REG_AW +: REG_AW];
            assign wb_data[s*DATA_W +: DATA_W] = unit_res[s];
        end
    endgenerate

    assert_wb_only_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (|wb_en) |-> !bnd_ready);

    assert_busy_after_issue_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bnd_valid && bnd_ready) |=> !bnd_ready);

endmodule

// File: tb/vliw_lockstep_issue_bench.sv
`timescale 1ns/1ps
module vliw_lockstep_issue_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bnd_valid = 1'b0;
    logic        bnd_ready;
    logic [11:0] bnd_op = '0, bnd_rd = '0, bnd_rs1 = '0, bnd_rs2 = '0;
    logic [31:0] bnd_imm = '0;
    logic [3:0]  wb_en;
    logic [11:0] wb_rd;
    logic [63:0] wb_data;

    always #4 clk = ~clk;

    vliw_lockstep_issue u_vliw_lockstep_issue (
        .clk(clk), .rst_n(rst_n), .bnd_valid(bnd_valid), .bnd_ready(bnd_ready),
        .bnd_op(bnd_op), .bnd_rd(bnd_rd), .bnd_rs1(bnd_rs1), .bnd_rs2(bnd_rs2),
        .bnd_imm(bnd_imm), .wb_en(wb_en), .wb_rd(wb_rd), .wb_data(wb_data)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;
    logic [15:0] m_rf  [8];
    logic [15:0] m_mem [16];
    logic [15:0] last_wb [4];

    task automatic check_eq(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [11:0] p3(input int a, input int b, input int c, input int d);
        return {d[2:0], c[2:0], b[2:0], a[2:0]};
    endfunction

    function automatic logic [31:0] p8(input int a, input int b, input int c, input int d);
        return {d[7:0], c[7:0], b[7:0], a[7:0]};
    endfunction

    function automatic logic [15:0] alu_ref(input logic [2:0] op, input logic [15:0] a, input logic [15:0] b, input logic [7:0] imm);
        case (op)
            3'd1: return a + b;
            3'd2: return a - b;
            3'd3: return a & b;
            3'd4: return a | b;
            3'd5: return a ^ b;
            3'd6: return a + {8'h00, imm};
            3'd7: return {8'h00, imm};
            default: return 16'h0;
        endcase
    endfunction

    function automatic string slot_tag(input int s);
        if (s < 2) return "R3";
        if (s == 2) return "R4";
        return "R5";
    endfunction

    task automatic run_bundle(input logic [11:0] ops, input logic [11:0] rds, input logic [11:0] s1s,
                              input logic [11:0] s2s, input logic [31:0] imms, input bit garbage);
        logic [15:0] ed [4];
        bit          ee [4];
        int          lat;
        int          st_addr;
        bit          do_st;
        logic [15:0] st_val;
        logic [2:0]  op;
        logic [15:0] a, b;
        logic [7:0]  imm;
        lat = 1; do_st = 0; st_addr = 0; st_val = '0;
        for (int s = 0; s < 4; s++) begin
            op  = ops[s*3 +: 3];
            a   = m_rf[s1s[s*3 +: 3]];
            b   = m_rf[s2s[s*3 +: 3]];
            imm = imms[s*8 +: 8];
            ee[s] = 0; ed[s] = '0;
            if (s < 2) begin
                ee[s] = (op != 3'd0);
                ed[s] = alu_ref(op, a, b, imm);
            end else if (s == 2) begin
                ee[s] = (op == 3'd1);
                ed[s] = a * b;
                if (op == 3'd1) lat = 3;
            end else begin
                st_addr = (int'(a) + int'(imm)) % 16;
                if (op == 3'd1) begin ee[s] = 1; ed[s] = m_mem[st_addr]; end
                if (op == 3'd2) begin do_st = 1; st_val = b; end
                if ((op == 3'd1 || op == 3'd2) && lat < 2) lat = 2;
            end
        end
        bnd_op = ops; bnd_rd = rds; bnd_rs1 = s1s; bnd_rs2 = s2s; bnd_imm = imms;
        bnd_valid = 1'b1;
        @(posedge clk);
        for (int k = 1; k <= lat + 1; k++) begin
            @(negedge clk);
            if (k == 1) begin
                if (garbage) begin
                    bnd_op = p3(7, 0, 0, 0); bnd_rd = p3(7, 0, 0, 0); bnd_imm = p8(8'hEE, 0, 0, 0);
                end else begin
                    bnd_valid = 1'b0;
                end
            end
            if (k < lat) begin
                check_eq("R10", "wb_en before commit", {28'h0, wb_en}, 32'h0);
                check_eq("R1", "ready while busy", {31'h0, bnd_ready}, 32'h0);
            end else if (k == lat) begin
                check_eq("R2", "ready in commit cycle", {31'h0, bnd_ready}, 32'h0);
                for (int s = 0; s < 4; s++) begin
                    check_eq(ee[s] ? "R2" : "R8", $sformatf("slot%0d wb_en", s), {31'h0, wb_en[s]}, {31'h0, ee[s]});
                    if (ee[s]) begin
                        check_eq(slot_tag(s), $sformatf("slot%0d wb_rd", s), {29'h0, wb_rd[s*3 +: 3]}, {29'h0, rds[s*3 +: 3]});
                        check_eq(slot_tag(s), $sformatf("slot%0d wb_data", s), {16'h0, wb_data[s*16 +: 16]}, {16'h0, ed[s]});
                    end
                    last_wb[s] = wb_data[s*16 +: 16];
                end
                bnd_valid = 1'b0;
            end else begin
                check_eq("R10", "wb_en after commit", {28'h0, wb_en}, 32'h0);
                check_eq("R2", "ready after commit", {31'h0, bnd_ready}, 32'h1);
            end
        end
        for (int s = 0; s < 4; s++)
            if (ee[s]) m_rf[rds[s*3 +: 3]] = ed[s];
        if (do_st) m_mem[st_addr] = st_val;
    endtask

    task automatic read_reg(input int r, output logic [15:0] v);
        run_bundle(p3(6, 0, 0, 0), p3(r, 0, 0, 0), p3(r, 0, 0, 0), p3(0, 0, 0, 0), p8(0, 0, 0, 0), 0);
        v = last_wb[0];
    endtask

    initial begin
        logic [15:0] v, saved;
        for (int i = 0; i < 8; i++) m_rf[i] = '0;
        for (int i = 0; i < 16; i++) m_mem[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_eq("R1", "ready after reset", {31'h0, bnd_ready}, 32'h1);
        check_eq("R1", "wb_en after reset", {28'h0, wb_en}, 32'h0);

        // Register initialisation via LI in both ALU slots
        run_bundle(p3(7, 7, 0, 0), p3(0, 1, 0, 0), 0, 0, p8(3, 200, 0, 0), 0);
        run_bundle(p3(7, 7, 0, 0), p3(2, 3, 0, 0), 0, 0, p8(17, 255, 0, 0), 0);
        run_bundle(p3(7, 7, 0, 0), p3(4, 5, 0, 0), 0, 0, p8(1, 128, 0, 0), 0);
        run_bundle(p3(7, 7, 0, 0), p3(6, 7, 0, 0), 0, 0, p8(90, 7, 0, 0), 0);

        // R3 sweep: every ALU opcode in both ALU slots
        for (int op = 0; op < 8; op++)
            for (int p = 0; p < 8; p++)
                run_bundle(p3(op, 7 - op, 0, 0), p3(p, (p + 4) % 8, 0, 0),
                           p3(p, (p + 1) % 8, 0, 0), p3((p + 3) % 8, (p + 6) % 8, 0, 0),
                           p8(p * 29 + 5, op * 17 + 3, 0, 0), 0);

        // R4 sweep: multiplier with ALU alongside
        for (int i = 0; i < 16; i++)
            run_bundle(p3(1, 0, 1, 0), p3((i + 2) % 8, 0, i % 8, 0),
                       p3(i % 8, 0, (i + 3) % 8, 0), p3((i + 5) % 8, 0, (i + 5) % 8, 0), 0, 0);

        // R2 sweep: every pattern of active slots
        for (int m = 0; m < 16; m++)
            run_bundle(p3(m[0] ? 1 : 0, m[1] ? 2 : 0, m[2] ? 1 : 0, m[3] ? 1 : 0),
                       p3(0, 1, 2, 3), p3(m % 8, 2, 4, 0), p3(1, m % 8, 6, 0), p8(0, 0, 0, m), 0);

        // R5 sweep: stores then loads with address wrap
        for (int i = 0; i < 16; i++)
            run_bundle(p3(0, 0, 0, 2), 0, p3(0, 0, 0, i % 8), p3(0, 0, 0, (i + 2) % 8), p8(0, 0, 0, i * 11), 0);
        for (int i = 0; i < 20; i++)
            run_bundle(p3(0, 0, 0, 1), p3(0, 0, 0, i % 8), p3(0, 0, 0, (i % 2) ? 6 : 5), 0, p8(0, 0, 0, i * 7), 0);

        // R5 directed wrap: 0xF0 + 0x13 = 0x103 -> address 3
        run_bundle(p3(7, 7, 0, 0), p3(6, 2, 0, 0), 0, 0, p8(8'hF0, 8'h3C, 0, 0), 0);
        run_bundle(p3(0, 0, 0, 2), 0, p3(0, 0, 0, 6), p3(0, 0, 0, 2), p8(0, 0, 0, 8'h13), 0);
        run_bundle(p3(7, 0, 0, 0), p3(0, 0, 0, 0), 0, 0, p8(0, 0, 0, 0), 0);
        run_bundle(p3(0, 0, 0, 1), p3(0, 0, 0, 1), p3(0, 0, 0, 0), 0, p8(0, 0, 0, 3), 0);
        check_eq("R5", "wrapped store/load", {16'h0, last_wb[3]}, 32'h3C);

        // R6: same-word write and read of r1
        run_bundle(p3(7, 0, 0, 0), p3(1, 0, 0, 0), 0, 0, p8(8'h40, 0, 0, 0), 0);
        run_bundle(p3(7, 1, 0, 0), p3(1, 2, 0, 0), p3(0, 1, 0, 0), p3(0, 1, 0, 0), p8(8'h11, 0, 0, 0), 0);
        check_eq("R6", "slot1 saw old r1", {16'h0, last_wb[1]}, 32'h80);
        read_reg(1, v);
        check_eq("R6", "r1 after word", {16'h0, v}, 32'h11);

        // R7: three slots write r3, multiply slot wins (0x11*0x11)
        run_bundle(p3(7, 7, 1, 0), p3(3, 3, 3, 0), p3(0, 0, 1, 0), p3(0, 0, 1, 0), p8(1, 2, 0, 0), 0);
        read_reg(3, v);
        check_eq("R7", "highest slot wins r3", {16'h0, v}, 32'h121);
        run_bundle(p3(7, 7, 0, 0), p3(4, 4, 0, 0), 0, 0, p8(5, 6, 0, 0), 0);
        read_reg(4, v);
        check_eq("R7", "slot1 over slot0 r4", {16'h0, v}, 32'h6);

        // R8: reserved opcodes in multiply and load/store slots are NOPs
        saved = m_rf[5];
        for (int c = 2; c < 8; c++)
            run_bundle(p3(0, 0, c, (c < 3) ? 3 : c), p3(5, 5, 5, 5), p3(1, 1, 1, 1), p3(1, 1, 1, 1), p8(9, 9, 9, 9), 0);
        read_reg(5, v);
        check_eq("R8", "r5 untouched by NOPs", {16'h0, v}, {16'h0, saved});

        // R9: a second word held on the input during a multiply is ignored
        saved = m_rf[7];
        run_bundle(p3(0, 0, 1, 0), p3(0, 0, 0, 0), p3(0, 0, 2, 0), p3(0, 0, 3, 0), 0, 1);
        read_reg(7, v);
        check_eq("R9", "r7 untouched by busy-time word", {16'h0, v}, {16'h0, saved});

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired act=running exp=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule